// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialiser

This block keeps an asynchronous DRAM of 1024 rows alive. After reset it waits out a mandatory power-up pause, then issues a series of wake-up RAS cycles and only then reports the memory as ready. From that point on it keeps an interval timer that adds one owed refresh every period, and pays each owed refresh back with one CAS-before-RAS (CBR) cycle. In a CBR cycle the DRAM takes the row from its own counter, so no address, write-enable or output-enable needs to be driven and the data bus stays released.

The block shares the strobe pins with the normal access controller. To run a cycle it raises a request, waits for a grant, drives RAS and both CAS strobes for the whole cycle including its precharge, and then hands the pins back with every strobe high. When no cycle is in progress, it reports every strobe as high. If the owed count is already full when another interval expires, the refresh deadline counts as missed. The block then drops its ready output, sets an overrun flag and repeats the full wake-up series before the memory is reported as ready again.

All timings are given as nanoseconds plus a clock frequency in MHz. Each one is rounded up to whole clock cycles, with a minimum of one.

Top module: `dram_refresh_init`

## Requirements
- R1: After reset, `init_done` stays low and `ras_n` stays high for at least the power-up pause (PWRUP_NS rounded up to cycles) before the first RAS fall.
- R2: Between the end of the power-up pause and the rise of `init_done`, exactly WAKE_CYCLES RAS falls occur (default 8), each of them a CBR cycle.
- R3: While `init_done` is high, one refresh is owed every REFI_NS (rounded up to cycles). Up to MAX_OWED owed refreshes are held, and each one is paid back by one CBR cycle.
- R4: In every cycle, both CAS strobes go low at least TCSR_NS cycles before `ras_n` falls. They are still low on the cycle in which RAS falls and stay low for at least TCHR_NS cycles after it.
- R5: `ras_n` stays low for at least TRAS_NS cycles. After it rises, all strobes stay high for at least the larger of TRP_NS and TRPC_NS before the pins are released.
- R6: `strobe_own` rises only in the cycle after `rfsh_gnt` was seen high while `rfsh_req` was high. While `strobe_own` is low, `ras_n`, `cas_lo_n` and `cas_hi_n` are all high.
- R7: `rfsh_req` stays high from the start of a cycle until the pins are released, and `strobe_own` is never high without `rfsh_req`.
- R8: If an interval expires while MAX_OWED refreshes are already owed, `init_done` falls and `overrun` rises. Exactly WAKE_CYCLES RAS cycles then run before `init_done` returns, and `overrun` clears when it does.
- R9: In reset and on the first cycle after it, `init_done`, `overrun`, `rfsh_req` and `strobe_own` are low and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_gnt | input | 1 | Grant of the strobe pins from the access controller |
| rfsh_req | output | 1 | Request for the strobe pins, high for a whole refresh cycle |
| strobe_own | output | 1 | High while this block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte-lane column strobe, active low |
| cas_hi_n | output | 1 | Upper byte-lane column strobe, active low |
| init_done | output | 1 | Power-up pause and wake-up cycles complete |
| overrun | output | 1 | Refresh deadline missed; wake-up replay in progress |

## Verification
The bench goes after the following corner cases:
- **End of the power-up pause.** A pause counter that is off by one would show as an early first RAS fall or as one wake-up cycle too many or too few before `init_done`.
- **Late and withheld grants.** A design that drives the strobes before the grant would move RAS while another master owns the pins.
- **Full owed count when another interval expires.** This must force the replay. A design that only saturated the count would keep `init_done` high while rows silently decay.
- **Cycle in flight when the overrun hits.** That cycle must count as the first wake-up cycle of the replay. Miscounting it lengthens or shortens the replay.

// File: rtl/dram_rfsh_pkg.sv
// Shared types and helpers for the DRAM refresh and power-up initialiser.
// Assumes: integer nanosecond timings and an integer clock frequency in MHz.
package dram_rfsh_pkg;

    // Refresh cycle sequencer states, in the order a cycle walks through them.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_SETUP,
        SQ_RASLO,
        SQ_HOLD,
        SQ_PRE
    } seq_state_t;

    // Top-level life phase of the memory.
    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_WAKE,
        PH_READY
    } phase_t;

    // Rounds a nanosecond time up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Free-running interval timer: pulses tick once every PERIOD cycles while
// run is high. It restarts from zero whenever run is low.
// Assumes PERIOD >= 2.
module rfsh_interval_timer #(
    parameter int PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Count cycles within the current interval; wrap at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Tick on the last cycle of each interval.
    always_comb tick = run && (cnt == LAST);

endmodule

// File: rtl/rfsh_debt_counter.sv
// Saturating count of refreshes owed to the DRAM. add raises the count,
// sub lowers it, and both together leave it unchanged. clear has priority.
// Assumes sub is only raised while the count is nonzero.
module rfsh_debt_counter #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic add,
    input  logic sub,
    output logic owed_nz,
    output logic full
);
    localparam int CW = $clog2(MAX_OWED + 1);
    localparam logic [CW-1:0] TOP = CW'(MAX_OWED);

    logic [CW-1:0] owed;

    // Track owed refreshes, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed <= '0;
        end else begin
            unique case ({add, sub})
                2'b10:   if (owed != TOP) owed <= owed + 1'b1;
                2'b01:   if (owed != '0)  owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    // Status decode of the owed count.
    always_comb begin
        owed_nz = (owed != '0);
        full    = (owed == TOP);
    end

endmodule

// File: rtl/rfsh_cbr_sequencer.sv
// Runs one CAS-before-RAS cycle per start request:
//   request -> grant -> CAS low -> RAS low -> CAS high -> precharge -> release.
// Every phase lasts a parameterised number of cycles (each >= 1).
// Assumes the grant is held for the whole cycle once it has been given.
module rfsh_cbr_sequencer
    import dram_rfsh_pkg::*;
#(
    parameter int CSR_CYC  = 1,
    parameter int CHR_CYC  = 1,
    parameter int HOLD_CYC = 2,
    parameter int PRE_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic gnt,
    output logic req,
    output logic own,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int MAXC = max2(max2(CSR_CYC, CHR_CYC), max2(HOLD_CYC, PRE_CYC));
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    st;
    logic [CW-1:0] cnt;
    logic          last;

    // The current phase has run its full length.
    always_comb last = (cnt == '0);

    // Walk the phases of one refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start) st <= SQ_REQ;
                end
                SQ_REQ: begin
                    if (gnt) begin
                        st  <= SQ_SETUP;
                        cnt <= CW'(CSR_CYC - 1);
                    end
                end
                SQ_SETUP: begin
                    if (last) begin
                        st  <= SQ_RASLO;
                        cnt <= CW'(CHR_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_RASLO: begin
                    if (last) begin
                        st  <= SQ_HOLD;
                        cnt <= CW'(HOLD_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (last) begin
                        st  <= SQ_PRE;
                        cnt <= CW'(PRE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_PRE: begin
                    if (last) st <= SQ_IDLE;
                    else      cnt <= cnt - 1'b1;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Decode the strobes and the handshake from the phase.
    always_comb begin
        req   = (st != SQ_IDLE);
        own   = (st == SQ_SETUP) || (st == SQ_RASLO) || (st == SQ_HOLD) || (st == SQ_PRE);
        ras_n = !((st == SQ_RASLO) || (st == SQ_HOLD));
        cas_n = !((st == SQ_SETUP) || (st == SQ_RASLO));
        done  = (st == SQ_PRE) && last;
    end

endmodule

// File: rtl/dram_refresh_init.sv
// DRAM refresh and power-up initialiser (top).
// Holds the power-up pause, then runs WAKE_CYCLES CBR cycles, then keeps
// paying one CBR refresh per interval. If the owed count saturates it
// replays the wake-up series.
// Assumes: one requester clock domain and a grant that stays high for a
// whole cycle. Both CAS lanes are driven together in each CBR cycle.
module dram_refresh_init
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ     = 50,
    parameter int PWRUP_NS    = 200000,
    parameter int REFI_NS     = 15600,
    parameter int TCSR_NS     = 5,
    parameter int TCHR_NS     = 10,
    parameter int TRAS_NS     = 60,
    parameter int TRP_NS      = 40,
    parameter int TRPC_NS     = 5,
    parameter int WAKE_CYCLES = 8,
    parameter int MAX_OWED    = 8,
    parameter int CAS_LANES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic strobe_own,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic init_done,
    output logic overrun
);
    localparam int PAUSE_CYC = ns_to_cycles(PWRUP_NS, CLK_MHZ);
    localparam int REFI_CYC  = max2(2, ns_to_cycles(REFI_NS, CLK_MHZ));
    localparam int CSR_CYC   = ns_to_cycles(TCSR_NS, CLK_MHZ);
    localparam int CHR_CYC   = ns_to_cycles(TCHR_NS, CLK_MHZ);
    localparam int RAS_CYC   = ns_to_cycles(TRAS_NS, CLK_MHZ);
    localparam int HOLD_CYC  = (RAS_CYC > CHR_CYC) ? (RAS_CYC - CHR_CYC) : 1;
    localparam int PRE_CYC   = max2(ns_to_cycles(TRP_NS, CLK_MHZ), ns_to_cycles(TRPC_NS, CLK_MHZ));
    localparam int PW        = $clog2(PAUSE_CYC + 1);
    localparam int WW        = $clog2(WAKE_CYCLES + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [WW-1:0] WAKE_LAST  = WW'(WAKE_CYCLES - 1);

    phase_t  phase;
    logic [PW-1:0] pause_cnt;
    logic [WW-1:0] wake_cnt;
    logic          ovr_flag;
    logic          tick, owed_nz, owed_full, seq_done, need, ovr_evt;
    logic          seq_cas_n;
    logic [CAS_LANES-1:0] cas_lane_n;

    // Interval timer runs only while the memory is ready.
    rfsh_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (phase == PH_READY),
        .tick (tick)
    );

    // Owed-refresh bookkeeping; emptied outside the ready phase and on overrun.
    rfsh_debt_counter #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  ((phase != PH_READY) || ovr_evt),
        .add    (tick),
        .sub    (seq_done && (phase == PH_READY)),
        .owed_nz(owed_nz),
        .full   (owed_full)
    );

    // One CBR cycle engine shared by the wake-up and the periodic refresh.
    rfsh_cbr_sequencer #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .HOLD_CYC(HOLD_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(need),
        .gnt  (rfsh_gnt),
        .req  (rfsh_req),
        .own  (strobe_own),
        .ras_n(ras_n),
        .cas_n(seq_cas_n),
        .done (seq_done)
    );

    // Decide whether another cycle is wanted and whether the deadline was missed.
    always_comb begin
        need    = (phase == PH_WAKE) || ((phase == PH_READY) && owed_nz);
        ovr_evt = (phase == PH_READY) && tick && owed_full;
    end

    // Advance through pause, wake-up and ready; re-enter wake-up on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_PAUSE;
            pause_cnt <= '0;
            wake_cnt  <= '0;
            ovr_flag  <= 1'b0;
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST) phase <= PH_WAKE;
                    else                         pause_cnt <= pause_cnt + 1'b1;
                end
                PH_WAKE: begin
                    if (seq_done) begin
                        if (wake_cnt == WAKE_LAST) begin
                            phase    <= PH_READY;
                            wake_cnt <= '0;
                            ovr_flag <= 1'b0;
                        end else begin
                            wake_cnt <= wake_cnt + 1'b1;
                        end
                    end
                end
                PH_READY: begin
                    if (ovr_evt) begin
                        phase    <= PH_WAKE;
                        wake_cnt <= '0;
                        ovr_flag <= 1'b1;
                    end
                end
                default: phase <= PH_PAUSE;
            endcase
        end
    end

    // Fan the shared CAS timing out to every byte lane.
    for (genvar g = 0; g < CAS_LANES; g++) begin : g_cas_lane
        assign cas_lane_n[g] = seq_cas_n;
    end

    // Port decode.
    always_comb begin
        cas_lo_n  = cas_lane_n[0];
        cas_hi_n  = cas_lane_n[CAS_LANES-1];
        init_done = (phase == PH_READY);
        overrun   = ovr_flag;
    end

endmodule

// File: rtl/dram_refresh_init_chk.sv
// Protocol checker for dram_refresh_init, attached by bind.
// Watches only the top-level ports; RAS width is measured with a counter.
module dram_refresh_init_chk #(
    parameter int RAS_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic rfsh_gnt,
    input logic rfsh_req,
    input logic strobe_own,
    input logic ras_n,
    input logic cas_lo_n,
    input logic cas_hi_n,
    input logic init_done,
    input logic overrun
);
    logic [7:0] low_run;

    // Count consecutive low samples of RAS, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n)      low_run <= '0;
        else if (low_run != 8'hFF) low_run <= low_run + 1'b1;
    end

    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_lo_n && !cas_hi_n && $past(!cas_lo_n && !cas_hi_n)));

    p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run >= 8'(RAS_CYC)));

    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_own |-> (ras_n && cas_lo_n && cas_hi_n));

    p_own_after_gnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_own) |-> $past(rfsh_gnt && rfsh_req));

    p_own_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_own |-> rfsh_req);

    p_ready_clears_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !overrun);

    p_ovr_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> !init_done);

endmodule

bind dram_refresh_init dram_refresh_init_chk #(.RAS_CYC(RAS_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rfsh_gnt  (rfsh_gnt),
    .rfsh_req  (rfsh_req),
    .strobe_own(strobe_own),
    .ras_n     (ras_n),
    .cas_lo_n  (cas_lo_n),
    .cas_hi_n  (cas_hi_n),
    .init_done (init_done),
    .overrun   (overrun)
);

// File: tb/dram_refresh_init_test.sv
// Bench: a behavioural reference model is stepped on each rising edge and
// compared with the ports on each falling edge, plus directed counts.
module dram_refresh_init_test;
    // Cycle values worked out by hand for the parameters below (50 MHz).
    localparam int PAUSE = 100;   // 2000 ns
    localparam int INTV  = 20;    // 400 ns
    localparam int CSR   = 1;
    localparam int CHR   = 1;
    localparam int HOLD  = 2;     // 60 ns RAS low = 3 cycles, minus CHR
    localparam int PRE   = 2;     // max(40 ns, 5 ns)
    localparam int WAKES = 8;
    localparam int MAXO  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rfsh_gnt = 1'b0;
    logic rfsh_req, strobe_own, ras_n, cas_lo_n, cas_hi_n, init_done, overrun;

    always #10 clk = ~clk;

    dram_refresh_init #(
        .CLK_MHZ(50), .PWRUP_NS(2000), .REFI_NS(400)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
        .strobe_own(strobe_own), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
        .cas_hi_n(cas_hi_n), .init_done(init_done), .overrun(overrun)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int since_rst = 0;
    int ras_falls = 0;
    int first_fall = -1;
    bit prev_ras = 1'b1;
    bit gnt_en = 1'b1;
    int gnt_delay = 0;
    int req_age = 0;

    // Reference model state.
    int m_ph, m_pc, m_wk, m_debt, m_tc, m_sq, m_sc;
    bit m_ovr;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Step the reference model on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_wk = 0; m_debt = 0; m_tc = 0; m_sq = 0; m_sc = 0; m_ovr = 0;
        end else begin
            bit fin, tk, want;
            int ph_was;
            fin  = (m_sq == 5) && (m_sc == 0);
            tk   = (m_ph == 2) && (m_tc == INTV - 1);
            want = (m_ph == 1) || (m_ph == 2 && m_debt > 0);
            // cycle phases: 0 idle,1 req,2 cas low,3 ras+cas low,4 ras low,5 precharge
            if (m_sq == 0) begin
                if (want) m_sq = 1;
            end else if (m_sq == 1) begin
                if (rfsh_gnt) begin m_sq = 2; m_sc = CSR - 1; end
            end else if (m_sc > 0) begin
                m_sc--;
            end else begin
                case (m_sq)
                    2: begin m_sq = 3; m_sc = CHR - 1; end
                    3: begin m_sq = 4; m_sc = HOLD - 1; end
                    4: begin m_sq = 5; m_sc = PRE - 1; end
                    default: m_sq = 0;
                endcase
            end
            ph_was = m_ph;
            if (m_ph == 0) begin
                if (m_pc == PAUSE - 1) m_ph = 1; else m_pc++;
            end else if (m_ph == 1) begin
                if (fin) begin
                    if (m_wk == WAKES - 1) begin m_ph = 2; m_wk = 0; m_ovr = 0; end
                    else m_wk++;
                end
            end else begin
                if (tk && m_debt == MAXO) begin
                    m_ph = 1; m_wk = 0; m_debt = 0; m_ovr = 1;
                end else begin
                    m_debt = m_debt + int'(tk) - int'(fin);
                end
            end
            if (ph_was == 2) m_tc = (m_tc == INTV - 1) ? 0 : m_tc + 1;
            else             m_tc = 0;
        end
    end

    // Compare with the model, track RAS falls and drive the grant, away from the edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) since_rst++;
        if (rst_n) begin
            check("R5 ras_n", ras_n, !(m_sq == 3 || m_sq == 4));
            check("R4 cas_lo_n", cas_lo_n, !(m_sq == 2 || m_sq == 3));
            check("R4 cas_hi_n", cas_hi_n, !(m_sq == 2 || m_sq == 3));
            check("R7 rfsh_req", rfsh_req, m_sq != 0);
            check("R6 strobe_own", strobe_own, m_sq >= 2);
            check("R3 init_done", init_done, m_ph == 2);
            check("R8 overrun", overrun, m_ovr);
            if (prev_ras && !ras_n) begin
                ras_falls++;
                if (first_fall < 0) first_fall = since_rst;
            end
        end
        prev_ras = ras_n;
        if (rfsh_req) req_age++; else req_age = 0;
        rfsh_gnt = gnt_en && rfsh_req && (req_age > gnt_delay);
    end

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_level(input bit want_done);
        int t = 0;
        while (init_done !== want_done && t < 5000) begin @(negedge clk); t++; end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run_cycles(3);
        // R9: reset outputs while held
        check("R9 init_done", init_done, 0);
        check("R9 rfsh_req", rfsh_req, 0);
        check("R9 strobe_own", strobe_own, 0);
        check("R9 strobes", {ras_n, cas_lo_n, cas_hi_n}, 3'b111);
        check("R9 overrun", overrun, 0);
        rst_n = 1'b1;
        since_rst = 0; ras_falls = 0; first_fall = -1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int f;
        apply_reset();
        // R1, R2: pause then exactly the wake-up series
        wait_level(1'b1);
        check("R1 first RAS fall after pause", int'(first_fall > PAUSE), 1);
        check("R2 wake-up RAS cycles", ras_falls, WAKES);
        check("R2 ready reached", init_done, 1);

        // R3: periodic refresh, about one per interval
        f = ras_falls;
        run_cycles(10 * INTV);
        check("R3 refreshes in ten intervals", int'((ras_falls - f) >= 9 && (ras_falls - f) <= 11), 1);

        // R6: late grant still gives well-formed cycles
        gnt_delay = 6;
        f = ras_falls;
        run_cycles(6 * INTV);
        check("R6 refreshes with late grant", int'((ras_falls - f) >= 5), 1);
        gnt_delay = 0;

        // R8: withhold the grant until the owed count saturates and overflows
        gnt_en = 1'b0;
        wait_level(1'b0);
        check("R8 overrun raised", overrun, 1);
        check("R8 no RAS while grant withheld", ras_n, 1);
        f = ras_falls;
        gnt_en = 1'b1;
        wait_level(1'b1);
        check("R8 replay RAS cycles", ras_falls - f, WAKES);
        check("R8 overrun cleared", overrun, 0);
        run_cycles(4 * INTV);

        // R9: reset in the middle of operation
        apply_reset();
        @(negedge clk);
        check("R9 not ready after reset", init_done, 0);
        check("R1 RAS idle during pause", ras_n, 1);
        run_cycles(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule